// File: doc/BRIEF.md
# Timer Channel Compare and Capture Unit

This block is one timer channel bound to a single I/O pin. It holds a 16-bit compare value and a 16-bit capture value and watches two free-running 16-bit timebases supplied from outside. When the pin is an input, a level change on it can latch the chosen timebase into the capture register and raise a capture flag. When the pin is an output, a compare hit can drive the pin high or low, or toggle it, in the cycle after the hit.

The compare test is greater-than-or-equal and wrap-aware, so a compare value already in the past still fires. Each write of the compare value arms the match once. The match disarms itself when it fires. In input mode the same compare hit acts as a timeout: it raises the match flag and leaves the pin alone. A sequencer drives a small command port. It loads the compare value, selects timebases, edge mode, pin action and direction, clears flags, and forces the pin level. The two flags go out as service requests.

Top module: `timer_channel`

## Requirements
- R1: After reset, pin_out is 0, pin_oe is 0 (input mode), svc_req is 0, capture_val is 0 and no match is armed.
- R2: Command code 1 loads ctrl_data as the compare value and arms the match. An armed match fires when (timebase − compare) mod 65536 is below 32768, so a value already passed fires. The fire is registered and sets svc_req[1] one cycle after the comparison holds.
- R3: The comparison wraps. A compare of 0xFFF0 fires at timebase 0x0005. A compare of 0x0010 does not fire at timebase 0xFFF0.
- R4: A match fires at most once per compare write. After it fires and its flag is cleared, later timebase values do not set svc_req[1] again until a new write.
- R5: Command code 2 writes the configuration. ctrl_data[0] selects the match timebase (0 = tb_a, 1 = tb_b). ctrl_data[1] selects the capture timebase the same way.
- R6: ctrl_data[3:2] of the configuration sets the input edge mode: 0 none, 1 rising, 2 falling, 3 both. A qualifying change on pin_in latches the selected timebase into capture_val and sets svc_req[0]. A transition that does not qualify leaves both unchanged.
- R7: ctrl_data[6] of the configuration sets the direction (1 = output), and pin_oe shows it. ctrl_data[5:4] sets the match action: 0 keep, 1 drive high, 2 drive low, 3 toggle. The action applies to pin_out in the cycle the match fires, and only in output mode.
- R8: In input mode a fired match is a timeout. It sets svc_req[1] and leaves pin_out unchanged.
- R9: Command code 4 sets pin_out to ctrl_data[0] on the next cycle. When it coincides with a firing match action, the forced level wins.
- R10: Command code 3 clears flags: ctrl_data[0] clears the capture flag and ctrl_data[1] clears the match flag. If a flag is set in the same cycle it is cleared, the set wins.
- R11: In output mode, transitions on pin_in neither capture nor set svc_req[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_a | input | 16 | Free-running timebase A |
| tb_b | input | 16 | Free-running timebase B |
| pin_in | input | 1 | Sampled level of the channel pin |
| ctrl_valid | input | 1 | Command strobe |
| ctrl_op | input | 3 | Command code (1 compare write, 2 config, 3 clear, 4 force) |
| ctrl_data | input | 16 | Command operand |
| pin_out | output | 1 | Driven pin level |
| pin_oe | output | 1 | Pin output enable (direction) |
| capture_val | output | 16 | Last captured timebase value |
| svc_req | output | 2 | Service requests: bit 1 match flag, bit 0 capture flag |

## Verification
Two things can collide in one cycle: a flag being set by hardware while the sequencer clears it, and a forced pin level arriving on the same cycle a match action fires. The first is provoked by changing pin_in on the same cycle a capture-flag clear is issued. The flag must read 1 afterwards. The second is provoked by issuing a force of 0 exactly one cycle after a compare write whose value is already in the past, with a drive-high action selected. pin_out must read 0 while the match flag still reads 1.

// File: rtl/tch_pkg.sv
package tch_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_WRCMP = 3'd1,
        OP_CFG   = 3'd2,
        OP_CLR   = 3'd3,
        OP_FORCE = 3'd4
    } tch_op_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } tch_edge_e;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'd0,
        ACT_HIGH   = 2'd1,
        ACT_LOW    = 2'd2,
        ACT_TOGGLE = 2'd3
    } tch_act_e;
endpackage

// File: rtl/tch_edge_det.sv
module tch_edge_det
    import tch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_in,
    input  tch_edge_e mode,
    input  logic      enable,
    output logic      hit
);
    typedef struct packed {
        logic prev;
        logic seen;
    } ed_t;

    ed_t  s_d, s_q;
    logic rise, fall;
    logic [1:0] mode_bits;

    always_comb begin
        s_d      = s_q;
        s_d.prev = pin_in;
        s_d.seen = 1'b1;
        mode_bits = mode;
        rise = s_q.seen &  pin_in & ~s_q.prev;
        fall = s_q.seen & ~pin_in &  s_q.prev;
        hit  = enable & ((rise & mode_bits[0]) | (fall & mode_bits[1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6
    rise_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> s_q.prev);
endmodule

// File: rtl/tch_ge_cmp.sv
module tch_ge_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] tb_a,
    input  logic [W-1:0] tb_b,
    input  logic         sel_b,
    input  logic [W-1:0] cmp,
    output logic         ge
);
    localparam int MSB = W - 1;
    logic [W-1:0] tb_sel, diff;

    always_comb begin
        tb_sel = sel_b ? tb_b : tb_a;
        diff   = tb_sel - cmp;
        ge     = ~diff[MSB];
    end
endmodule

// File: rtl/tch_pin_next.sv
module tch_pin_next
    import tch_pkg::*;
(
    input  logic     pin_q,
    input  tch_act_e act,
    input  logic     fire,
    input  logic     is_out,
    input  logic     force_en,
    input  logic     force_val,
    output logic     pin_d
);
    always_comb begin
        pin_d = pin_q;
        if (force_en) begin
            pin_d = force_val;
        end else if (fire && is_out) begin
            case (act)
                ACT_HIGH:   pin_d = 1'b1;
                ACT_LOW:    pin_d = 1'b0;
                ACT_TOGGLE: pin_d = ~pin_q;
                default:    pin_d = pin_q;
            endcase
        end
    end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import tch_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tb_a,
    input  logic [W-1:0] tb_b,
    input  logic         pin_in,
    input  logic         ctrl_valid,
    input  logic [2:0]   ctrl_op,
    input  logic [W-1:0] ctrl_data,
    output logic         pin_out,
    output logic         pin_oe,
    output logic [W-1:0] capture_val,
    output logic [1:0]   svc_req
);
    typedef struct packed {
        logic [W-1:0] cmp;
        logic [W-1:0] cap;
        logic         armed;
        logic         fcap;
        logic         fmatch;
        logic         msel;
        logic         csel;
        logic [1:0]   emode;
        logic [1:0]   act;
        logic         dir_out;
        logic         pin;
    } st_t;

    st_t      s_d, s_q;
    tch_op_e  op;
    logic     ge, fire, edge_hit, is_wr, is_force, pin_nx;
    logic [W-1:0] tb_cap;

    assign op       = tch_op_e'(ctrl_op);
    assign is_wr    = ctrl_valid && (op == OP_WRCMP);
    assign is_force = ctrl_valid && (op == OP_FORCE);

    tch_ge_cmp #(.W(W)) cmp_i (
        .tb_a  (tb_a),
        .tb_b  (tb_b),
        .sel_b (s_q.msel),
        .cmp   (s_q.cmp),
        .ge    (ge)
    );

    tch_edge_det edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .mode   (tch_edge_e'(s_q.emode)),
        .enable (!s_q.dir_out),
        .hit    (edge_hit)
    );

    assign fire = s_q.armed && ge;

    tch_pin_next pin_i (
        .pin_q     (s_q.pin),
        .act       (tch_act_e'(s_q.act)),
        .fire      (fire),
        .is_out    (s_q.dir_out),
        .force_en  (is_force),
        .force_val (ctrl_data[0]),
        .pin_d     (pin_nx)
    );

    always_comb begin
        s_d     = s_q;
        tb_cap  = s_q.csel ? tb_b : tb_a;
        s_d.pin = pin_nx;
        if (fire) begin
            s_d.armed  = 1'b0;
            s_d.fmatch = 1'b1;
        end
        if (edge_hit) begin
            s_d.cap  = tb_cap;
            s_d.fcap = 1'b1;
        end
        if (ctrl_valid) begin
            case (op)
                OP_WRCMP: begin
                    s_d.cmp   = ctrl_data;
                    s_d.armed = 1'b1;
                end
                OP_CFG: begin
                    s_d.msel    = ctrl_data[0];
                    s_d.csel    = ctrl_data[1];
                    s_d.emode   = ctrl_data[3:2];
                    s_d.act     = ctrl_data[5:4];
                    s_d.dir_out = ctrl_data[6];
                end
                OP_CLR: begin
                    if (ctrl_data[0] && !edge_hit) s_d.fcap   = 1'b0;
                    if (ctrl_data[1] && !fire)     s_d.fmatch = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin_out     = s_q.pin;
    assign pin_oe      = s_q.dir_out;
    assign capture_val = s_q.cap;
    assign svc_req     = {s_q.fmatch, s_q.fcap};

    // R4
    one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !is_wr) |=> !s_q.armed);
    // R2
    match_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.fmatch) |-> $past(s_q.armed));
    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_hit |=> $stable(s_q.cap));
    // R8
    in_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.dir_out && !is_force) |=> $stable(s_q.pin));
    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> s_q.fcap);
    // R11
    out_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dir_out |-> !edge_hit);
endmodule

// File: tb/timer_channel_tb.sv
module timer_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tb_a = '0, tb_b = '0;
    logic        pin_in = 1'b0;
    logic        ctrl_valid = 1'b0;
    logic [2:0]  ctrl_op = '0;
    logic [15:0] ctrl_data = '0;
    logic        pin_out, pin_oe;
    logic [15:0] capture_val;
    logic [1:0]  svc_req;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    timer_channel dut_i (
        .clk(clk), .rst_n(rst_n), .tb_a(tb_a), .tb_b(tb_b), .pin_in(pin_in),
        .ctrl_valid(ctrl_valid), .ctrl_op(ctrl_op), .ctrl_data(ctrl_data),
        .pin_out(pin_out), .pin_oe(pin_oe), .capture_val(capture_val),
        .svc_req(svc_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmd(input logic [2:0] o, input logic [15:0] d);
        ctrl_valid = 1'b1; ctrl_op = o; ctrl_data = d;
        @(negedge clk);
        ctrl_valid = 1'b0; ctrl_op = '0; ctrl_data = '0;
    endtask

    task automatic clr_all();
        cmd(3'd3, 16'h0003);
    endtask

    task automatic t_reset();
        chk("R1 pin_out", pin_out, 0);
        chk("R1 pin_oe", pin_oe, 0);
        chk("R1 svc_req", svc_req, 0);
        chk("R1 capture", capture_val, 0);
    endtask

    task automatic t_match_basic();
        tb_a = 16'd100;
        cmd(3'd1, 16'd50); step();
        chk("R2 past fires", svc_req[1], 1);
        clr_all();
        chk("R10 clear match", svc_req[1], 0);
        cmd(3'd1, 16'd200); step(3);
        chk("R2 future waits", svc_req[1], 0);
        tb_a = 16'd200; step();
        chk("R2 reach fires", svc_req[1], 1);
        clr_all();
        tb_a = 16'd300; step(3);
        chk("R4 no refire", svc_req[1], 0);
    endtask

    task automatic t_wrap();
        tb_a = 16'h0005;
        cmd(3'd1, 16'hFFF0); step();
        chk("R3 wrap fires", svc_req[1], 1);
        clr_all();
        tb_a = 16'hFFF0;
        cmd(3'd1, 16'h0010); step(3);
        chk("R3 wrap holds", svc_req[1], 0);
        tb_a = 16'h0010; step(); clr_all();
    endtask

    task automatic t_tbsel();
        cmd(3'd2, 16'h0001);
        tb_a = 16'd1000; tb_b = 16'd10;
        cmd(3'd1, 16'd500); step(3);
        chk("R5 uses tb_b", svc_req[1], 0);
        tb_b = 16'd600; step();
        chk("R5 tb_b fires", svc_req[1], 1);
        clr_all();
    endtask

    task automatic t_edges();
        cmd(3'd2, 16'h0006);
        tb_b = 16'h1234; pin_in = 1'b1; step();
        chk("R6 rise flag", svc_req[0], 1);
        chk("R6 rise cap", capture_val, 16'h1234);
        clr_all();
        tb_b = 16'h2222; pin_in = 1'b0; step();
        chk("R6 fall ignored", svc_req[0], 0);
        chk("R6 cap kept", capture_val, 16'h1234);
        cmd(3'd2, 16'h000A);
        pin_in = 1'b1; step();
        chk("R6 rise ignored", svc_req[0], 0);
        tb_b = 16'h3333; pin_in = 1'b0; step();
        chk("R6 fall cap", capture_val, 16'h3333);
        clr_all();
        cmd(3'd2, 16'h000C);
        tb_a = 16'h4444; pin_in = 1'b1; step();
        chk("R5 cap tb_a", capture_val, 16'h4444);
        clr_all();
        cmd(3'd2, 16'h0000);
        pin_in = 1'b0; step();
        chk("R6 none mode", svc_req[0], 0);
    endtask

    task automatic t_same_cycle_clear();
        cmd(3'd2, 16'h000C); clr_all();
        pin_in = 1'b1;
        cmd(3'd3, 16'h0001);
        chk("R10 set wins", svc_req[0], 1);
        clr_all();
    endtask

    task automatic t_actions();
        tb_a = 16'd100;
        cmd(3'd2, 16'h0050);
        chk("R7 oe", pin_oe, 1);
        cmd(3'd1, 16'd50); step();
        chk("R7 drive high", pin_out, 1);
        cmd(3'd2, 16'h0060);
        cmd(3'd1, 16'd50); step();
        chk("R7 drive low", pin_out, 0);
        cmd(3'd2, 16'h0070);
        cmd(3'd1, 16'd50); step();
        chk("R7 toggle 1", pin_out, 1);
        cmd(3'd1, 16'd50); step();
        chk("R7 toggle 2", pin_out, 0);
        cmd(3'd2, 16'h0040);
        cmd(3'd1, 16'd50); step();
        chk("R7 keep", pin_out, 0);
        clr_all();
        cmd(3'd2, 16'h004C);
        pin_in = 1'b0; step();
        chk("R11 no cap out", svc_req[0], 0);
    endtask

    task automatic t_timeout();
        cmd(3'd2, 16'h0010); clr_all();
        cmd(3'd1, 16'd50); step();
        chk("R8 timeout flag", svc_req[1], 1);
        chk("R8 pin held", pin_out, 0);
        chk("R8 oe low", pin_oe, 0);
        clr_all();
    endtask

    task automatic t_force();
        cmd(3'd4, 16'h0001);
        chk("R9 force high", pin_out, 1);
        cmd(3'd2, 16'h0050); clr_all();
        cmd(3'd4, 16'h0000);
        cmd(3'd1, 16'd50);
        cmd(3'd4, 16'h0000);
        chk("R9 force wins", pin_out, 0);
        chk("R9 match flag", svc_req[1], 1);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step();
        t_reset();
        t_match_basic();
        t_wrap();
        t_tbsel();
        t_edges();
        t_same_cycle_clear();
        t_actions();
        t_timeout();
        t_force();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule